// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block decides which of 32 clock frequency plans a clock generator runs. Five board straps share their pins with clock outputs. While power-on reset is held, the block samples their levels into a 5-bit latch on every clock edge. When reset is released the latch freezes and the pins change over to driving clocks. After reset, a control byte written by software picks the source of the frequency code. The code comes either from the frozen straps or from a 5-bit field spread across the same control byte.

The selected code addresses a computed rate table. The table gives the CPU, AGP, PCI and IOAPIC output rates as rate words in units of 10 kHz. A downstream synthesizer turns these words into divider settings. The rate words are registered. They reload only when the selected code changes, and each reload raises a one-cycle strobe so the synthesizer can retune. The block also reports the frozen straps in inverted form, as status bits for software.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: On every rising clock edge with `rst_n` low, the strap latch takes `strap_pin_i`. From the first edge with `rst_n` high onward, the latch holds the value taken at the last reset edge, and later pin activity has no effect on it.
- R2: `pin_oe_o` is all zeros after any edge with `rst_n` low. It is all ones from the first rising edge with `rst_n` high.
- R3: The control byte resets to 0x00. While its bit 3 is 0, the selected code equals the latched straps, whatever the other control bits hold.
- R4: While control bit 3 is 1, the selected code is {bit2, bit1, bit6, bit5, bit4} of the control byte, listed from code bit 4 down to code bit 0. A write with `cfg_we_i` high loads `cfg_wdata_i` at the clock edge.
- R5: `strap_inv_o` is the bitwise inverse of the strap latch.
- R6: Code 00000 gives CPU 20000, AGP 8000 and PCI 4000. Code 01101 gives CPU 10000, AGP 6667 and PCI 3333. Code 11011 gives CPU 7800 and AGP 7800. Code 10010 gives CPU 11500 and AGP 7667. Code 11111 gives CPU 13333 and AGP 6667. All rates are in 10 kHz units.
- R7: For every code, the PCI rate is the AGP rate halved and rounded down, and the IOAPIC rate is the PCI rate halved and rounded down.
- R8: At the first edge after reset, and at any edge where the selected code differs from `fsel_code_o`, the rate words and `fsel_code_o` load the new code. `rate_upd_o` is high for the following cycle.
- R9: While the selected code equals `fsel_code_o`, `rate_upd_o` stays low and the rate words hold. This also covers a change of source that yields the same code, and writes that touch only unused control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; the strap sampling window |
| strap_pin_i | input | 5 | Levels seen on the shared strap/clock pins |
| cfg_we_i | input | 1 | Write strobe for the control byte |
| cfg_wdata_i | input | 8 | Control byte write data |
| pin_oe_o | output | 5 | Output enables for the shared pins |
| strap_inv_o | output | 5 | Inverted latched straps, status for software |
| fsel_code_o | output | 5 | Frequency code currently applied to the rate words |
| cpu_rate_o | output | 15 | CPU rate word, 10 kHz units |
| agp_rate_o | output | 15 | AGP rate word, 10 kHz units |
| pci_rate_o | output | 15 | PCI rate word, 10 kHz units |
| apic_rate_o | output | 15 | IOAPIC rate word, 10 kHz units |
| rate_upd_o | output | 1 | One-cycle strobe when the rate words reload |

## Verification
The straps are given one level early in reset and a different level just before release. This shows whether the frozen value comes from the last reset edge or from an earlier one. Pins toggled after reset expose any leak into the latch or the readback. Register codes 01101, 11011 and 10010 are chosen so that both halves of the split register field and the halving chain are exercised. Two further cases separate a true code change from a write that leaves the code as it is: a switch to register source carrying the same code as the straps, and a write touching only bits the block ignores. A second reset with all straps high checks the other end of the table and the control byte's return to zero.

// File: rtl/fsel_pkg.sv
// Shared widths, rate record and the frequency plan table.
// Assumes rate words are in 10 kHz units and fit in RATE_W bits.
package fsel_pkg;

    localparam int FSEL_W = 5;
    localparam int RATE_W = 15;
    localparam int CFG_W  = 8;

    typedef struct packed {
        logic [RATE_W-1:0] cpu;
        logic [RATE_W-1:0] agp;
    } rate_pair_t;

    // Frequency plan: CPU and AGP rate for each 5-bit select code.
    function automatic rate_pair_t fsel_lookup(input logic [FSEL_W-1:0] code);
        rate_pair_t r;
        case (code)
            5'd0:  r = '{cpu: 15'd20000, agp: 15'd8000};
            5'd1:  r = '{cpu: 15'd19000, agp: 15'd7600};
            5'd2:  r = '{cpu: 15'd18000, agp: 15'd7200};
            5'd3:  r = '{cpu: 15'd17000, agp: 15'd6800};
            5'd4:  r = '{cpu: 15'd16600, agp: 15'd6640};
            5'd5:  r = '{cpu: 15'd16000, agp: 15'd6400};
            5'd6:  r = '{cpu: 15'd15000, agp: 15'd7500};
            5'd7:  r = '{cpu: 15'd14500, agp: 15'd7250};
            5'd8:  r = '{cpu: 15'd14000, agp: 15'd7000};
            5'd9:  r = '{cpu: 15'd13600, agp: 15'd6800};
            5'd10: r = '{cpu: 15'd13000, agp: 15'd6500};
            5'd11: r = '{cpu: 15'd12400, agp: 15'd6200};
            5'd12: r = '{cpu: 15'd6667,  agp: 15'd6667};
            5'd13: r = '{cpu: 15'd10000, agp: 15'd6667};
            5'd14: r = '{cpu: 15'd11800, agp: 15'd7867};
            5'd15: r = '{cpu: 15'd13333, agp: 15'd6667};
            5'd16: r = '{cpu: 15'd6680,  agp: 15'd6680};
            5'd17: r = '{cpu: 15'd10020, agp: 15'd6680};
            5'd18: r = '{cpu: 15'd11500, agp: 15'd7667};
            5'd19: r = '{cpu: 15'd13340, agp: 15'd6670};
            5'd20: r = '{cpu: 15'd6680,  agp: 15'd6680};
            5'd21: r = '{cpu: 15'd10020, agp: 15'd6680};
            5'd22: r = '{cpu: 15'd11000, agp: 15'd7333};
            5'd23: r = '{cpu: 15'd13340, agp: 15'd6670};
            5'd24: r = '{cpu: 15'd10500, agp: 15'd7000};
            5'd25: r = '{cpu: 15'd9000,  agp: 15'd6000};
            5'd26: r = '{cpu: 15'd8500,  agp: 15'd5667};
            5'd27: r = '{cpu: 15'd7800,  agp: 15'd7800};
            5'd28: r = '{cpu: 15'd6667,  agp: 15'd6667};
            5'd29: r = '{cpu: 15'd10000, agp: 15'd6667};
            5'd30: r = '{cpu: 15'd7500,  agp: 15'd7500};
            default: r = '{cpu: 15'd13333, agp: 15'd6667};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsel_strap_capture.sv
// Strap sampling window and pin direction changeover.
// Latch is loaded on each edge while rst_n is low and frozen afterwards;
// the shared pins are enabled as outputs from the first edge out of reset.
// Assumes rst_n is already synchronous to clk.
module fsel_strap_capture #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] strap_q_o,
    output logic [WIDTH-1:0] oe_o
);

    // Sample pins during reset, hold once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q_o <= pin_i;
        end
    end

    // Pins are inputs in reset, outputs afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o <= '0;
        end else begin
            oe_o <= '1;
        end
    end

    AST_OE_OFF_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (oe_o == '0)); // R2

    AST_OE_ON_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (&oe_o)); // R2

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q_o)); // R1

endmodule

// File: rtl/fsel_source_sel.sv
// Control byte register and frequency code source multiplexer.
// Bit SRC_BIT picks the source; the register code is gathered from
// bits {2,1,6,5,4} (code bit 4 down to 0). Register resets to zero.
module fsel_source_sel
    import fsel_pkg::*;
#(
    parameter int SRC_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CFG_W-1:0]  wdata_i,
    input  logic [FSEL_W-1:0] strap_i,
    output logic [FSEL_W-1:0] sel_o
);

    logic [CFG_W-1:0]  cfg_q;
    logic [FSEL_W-1:0] reg_code;
    logic              unused_cfg_bits;

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= wdata_i;
        end
    end

    // Gather the split register code field.
    always_comb begin
        reg_code = {cfg_q[2], cfg_q[1], cfg_q[6], cfg_q[5], cfg_q[4]};
    end

    // Choose strap or register code.
    always_comb begin
        sel_o = cfg_q[SRC_BIT] ? reg_code : strap_i;
    end

    assign unused_cfg_bits = ^{cfg_q[7], cfg_q[0]};

    AST_RESET_STRAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sel_o == strap_i)); // R3

endmodule

// File: rtl/fsel_rate_table.sv
// Registered frequency plan lookup. Reloads when the selected code
// differs from the applied code (or on the first edge after reset)
// and pulses upd_o for one cycle. PCI and IOAPIC words are successive halvings.
module fsel_rate_table
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] sel_i,
    output logic [FSEL_W-1:0] code_o,
    output logic [RATE_W-1:0] cpu_o,
    output logic [RATE_W-1:0] agp_o,
    output logic [RATE_W-1:0] pci_o,
    output logic [RATE_W-1:0] apic_o,
    output logic              upd_o
);

    logic       loaded_q;
    logic       reload;
    rate_pair_t look;
    logic [RATE_W-1:0] pci_next;

    // Decide whether the rate words must be refreshed.
    always_comb begin
        reload   = !loaded_q || (sel_i != code_o);
        look     = fsel_lookup(sel_i);
        pci_next = look.agp >> 1;
    end

    // Rate word registers and update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            code_o   <= '0;
            cpu_o    <= '0;
            agp_o    <= '0;
            pci_o    <= '0;
            apic_o   <= '0;
            upd_o    <= 1'b0;
        end else begin
            loaded_q <= 1'b1;
            upd_o    <= reload;
            if (reload) begin
                code_o <= sel_i;
                cpu_o  <= look.cpu;
                agp_o  <= look.agp;
                pci_o  <= pci_next;
                apic_o <= pci_next >> 1;
            end
        end
    end

    AST_RELOAD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && (sel_i != code_o)) |=> (upd_o && (code_o == $past(sel_i)))); // R8

    AST_HOLD_WHEN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && (sel_i == code_o)) |=> (!upd_o && $stable(cpu_o) && $stable(agp_o))); // R9

endmodule

// File: rtl/fsel_strap_ctrl.sv
// Top of the strap-latched frequency select controller.
// Connects strap capture, source selection and the registered rate table,
// and drives the inverted strap readback. Synchronous active-low reset.
module fsel_strap_ctrl
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        strap_pin_i,
    input  logic              cfg_we_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [4:0]        pin_oe_o,
    output logic [4:0]        strap_inv_o,
    output logic [4:0]        fsel_code_o,
    output logic [14:0]       cpu_rate_o,
    output logic [14:0]       agp_rate_o,
    output logic [14:0]       pci_rate_o,
    output logic [14:0]       apic_rate_o,
    output logic              rate_upd_o
);

    logic [FSEL_W-1:0] strap_q;
    logic [FSEL_W-1:0] sel_code;

    fsel_strap_capture #(.WIDTH(FSEL_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (strap_pin_i),
        .strap_q_o (strap_q),
        .oe_o      (pin_oe_o)
    );

    fsel_source_sel #(.SRC_BIT(3)) u_source (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .strap_i (strap_q),
        .sel_o   (sel_code)
    );

    fsel_rate_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_code),
        .code_o (fsel_code_o),
        .cpu_o  (cpu_rate_o),
        .agp_o  (agp_rate_o),
        .pci_o  (pci_rate_o),
        .apic_o (apic_rate_o),
        .upd_o  (rate_upd_o)
    );

    // Status readback reports the latched straps inverted.
    always_comb begin
        strap_inv_o = ~strap_q;
    end

endmodule

// File: tb/fsel_strap_ctrl_test.sv
module fsel_strap_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_pin_i = 5'b11111;
    logic        cfg_we_i = 1'b0;
    logic [7:0]  cfg_wdata_i = 8'h00;
    logic [4:0]  pin_oe_o, strap_inv_o, fsel_code_o;
    logic [14:0] cpu_rate_o, agp_rate_o, pci_rate_o, apic_rate_o;
    logic        rate_upd_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fsel_strap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .strap_pin_i(strap_pin_i),
        .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .pin_oe_o(pin_oe_o), .strap_inv_o(strap_inv_o), .fsel_code_o(fsel_code_o),
        .cpu_rate_o(cpu_rate_o), .agp_rate_o(agp_rate_o), .pci_rate_o(pci_rate_o),
        .apic_rate_o(apic_rate_o), .rate_upd_o(rate_upd_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_rates(input string req, input int code, input int cpu, input int agp);
        chk(req, "code", fsel_code_o, code);
        chk(req, "cpu", cpu_rate_o, cpu);
        chk(req, "agp", agp_rate_o, agp);
        chk("R7", "pci", pci_rate_o, agp / 2);
        chk("R7", "apic", apic_rate_o, (agp / 2) / 2);
    endtask

    // Hold reset with early straps, change them before release.
    task automatic t_reset(input logic [4:0] early, input logic [4:0] late,
                           input int cpu, input int agp);
        rst_n = 1'b0;
        strap_pin_i = early;
        step(); step(); step();
        chk("R2", "oe in reset", pin_oe_o, 0);
        chk("R5", "readback in reset", strap_inv_o, ~early & 5'h1f);
        strap_pin_i = late;
        step();
        rst_n = 1'b1;
        step();
        chk("R2", "oe after reset", pin_oe_o, 5'h1f);
        chk("R8", "first load strobe", rate_upd_o, 1);
        chk("R5", "readback frozen", strap_inv_o, ~late & 5'h1f);
        chk_rates("R1", late, cpu, agp);
        step();
        chk("R8", "strobe one cycle", rate_upd_o, 0);
    endtask

    // Pins move after reset: latch, code and readback must not follow.
    task automatic t_strap_ignored(input logic [4:0] held);
        int seen = 0;
        strap_pin_i = ~held;
        for (int i = 0; i < 5; i++) begin
            step();
            if (rate_upd_o) seen++;
            strap_pin_i = strap_pin_i ^ 5'b10101;
        end
        chk("R1", "no strobe on pin change", seen, 0);
        chk("R5", "readback ignores pins", strap_inv_o, ~held & 5'h1f);
        chk("R1", "code ignores pins", fsel_code_o, held);
    endtask

    // Write the control byte; expect a reload with the given rates.
    task automatic t_write_change(input string req, input logic [7:0] b,
                                  input int code, input int cpu, input int agp);
        cfg_we_i = 1'b1;
        cfg_wdata_i = b;
        step();
        cfg_we_i = 1'b0;
        chk("R8", "no strobe before reload", rate_upd_o, 0);
        step();
        chk("R8", "strobe on reload", rate_upd_o, 1);
        chk_rates(req, code, cpu, agp);
        step();
        chk("R8", "strobe falls", rate_upd_o, 0);
    endtask

    // Write the control byte; selected code unchanged, nothing moves.
    task automatic t_write_same(input string req, input logic [7:0] b, input int code);
        int seen = 0;
        int cpu0 = cpu_rate_o;
        cfg_we_i = 1'b1;
        cfg_wdata_i = b;
        step();
        cfg_we_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (rate_upd_o) seen++;
            step();
        end
        chk(req, "no strobe", seen, 0);
        chk(req, "code held", fsel_code_o, code);
        chk(req, "cpu held", cpu_rate_o, cpu0);
    endtask

    initial begin
        step();
        // R1 R6: last reset edge decides; code 00000
        t_reset(5'b11111, 5'b00000, 20000, 8000);
        chk("R6", "pci code0", pci_rate_o, 4000);
        t_strap_ignored(5'b00000);
        // R4: register code 01101 -> byte 0x5A
        t_write_change("R4", 8'h5A, 13, 10000, 6667);
        chk("R6", "pci code13", pci_rate_o, 3333);
        // R4: code 11011 -> 0x3E, code 10010 -> 0x2C
        t_write_change("R4", 8'h3E, 27, 7800, 7800);
        t_write_change("R6", 8'h2C, 18, 11500, 7667);
        // R3: bit3 clear with other fields set -> back to straps
        t_write_change("R3", 8'h76, 0, 20000, 8000);
        // R9: register source carrying the strap code
        t_write_same("R9", 8'h08, 0);
        // R9: only unused bits touched, strap source
        t_write_same("R9", 8'h81, 0);
        // R3: second reset, straps high, byte back to zero
        t_reset(5'b00000, 5'b11111, 13333, 6667);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule